// File: doc/BRIEF.md
# Quadrature Mixer with Quarter-Rate and Half-Rate Local Oscillator

This block sits after the interpolation filters of a transmit path and frequency-shifts a pair of in-phase and quadrature sample streams at the interpolated rate. The local oscillator can be a quarter of the sample rate, half of the sample rate, or switched off so that samples pass unchanged. The oscillator values are only 0, +1 and -1, so every product reduces to a select or a saturating negation and no multiplier is built.

Two mixing styles are offered. The complex style rotates the I/Q vector and gives an image-rejected intermediate-frequency pair for a downstream analog I/Q modulator. The real style mixes each channel on its own and gives an image pair around the oscillator frequency. A 2-bit phase counter steps once per accepted sample. It returns to zero on reset and whenever the mode inputs change, so the first sample after any reconfiguration always sees oscillator phase zero.

Top module: `quad_mixer`

## Requirements
- R1: While reset is asserted, and directly after it, `out_valid` is 0 and both outputs are 0.
- R2: A sample accepted with `in_valid`=1 appears on the outputs one clock later, with `out_valid`=1. `out_valid` is 0 in the cycle after any cycle with `in_valid`=0.
- R3: With `lo_sel` = 2'b00 or 2'b11 (oscillator off), `out_i`=`in_i` and `out_q`=`in_q`, in both mixing styles.
- R4: With `lo_sel` = 2'b01 (half rate), both channels are multiplied by +1 at even phases and by -1 at odd phases. The mixing style has no effect in this mode.
- R5: With `lo_sel` = 2'b10 and `cplx_en`=1, the cosine is 1,0,-1,0 and the sine is 0,1,0,-1 over phases 0..3. The outputs are out_i = I·cos − Q·sin and out_q = I·sin + Q·cos, which gives (I,Q), (−Q,I), (−I,−Q), (Q,−I).
- R6: With `lo_sel` = 2'b10 and `cplx_en`=0, each channel is multiplied by the cosine alone, which gives (I,Q), (0,0), (−I,−Q), (0,0).
- R7: Negating the most negative 12-bit code (−2048) gives +2047.
- R8: The phase advances by one, modulo 4, only on cycles with `in_valid`=1. Idle cycles hold it.
- R9: Any change of `lo_sel` or `cplx_en`, whether or not a sample is present in that cycle, restarts the phase at 0. The sample accepted in the cycle of the change uses phase 0.
- R10: While `in_valid`=0, `out_i` and `out_q` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the interpolated sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_i | input | 12 | In-phase sample, two's complement |
| in_q | input | 12 | Quadrature sample, two's complement |
| lo_sel | input | 2 | Oscillator select: 00 off, 01 half rate, 10 quarter rate, 11 off |
| cplx_en | input | 1 | 1 for complex (rotating) mixing, 0 for real per-channel mixing |
| out_valid | output | 1 | Output sample updated this cycle |
| out_i | output | 12 | Mixed in-phase output |
| out_q | output | 12 | Mixed quadrature output |

## Verification
Every combination of oscillator select and mixing style is swept with I and Q values drawn across the full signed range, using different stride patterns for I and Q. Because I and Q differ in every sample, a swapped channel or a wrong sign in the rotation shows up at once. Idle cycles are placed at irregular points, which separates a phase that advances per cycle from one that advances per sample, and also checks that the outputs hold. Directed sequences change the mode in the middle of a stream and feed −2048 at odd phases, which isolates the phase restart and the saturating negation.

// File: rtl/qmix_pkg.sv
`timescale 1ns/1ps
package qmix_pkg;
  typedef enum logic [1:0] {
    LO_OFF   = 2'd0,
    LO_HALF  = 2'd1,
    LO_QUART = 2'd2,
    LO_OFF2  = 2'd3
  } lo_e;
  localparam int unsigned PH_W = 2;
endpackage

// File: rtl/qmix_phase.sv
`timescale 1ns/1ps
module qmix_phase
  import qmix_pkg::*;
#(
  parameter int unsigned PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [1:0]    lo_sel,
  input  logic          cplx_en,
  output logic [PW-1:0] ph_eff,
  output logic          mode_chg
);
  localparam int unsigned MW = 3;
  logic [MW-1:0] mode_q;
  logic [PW-1:0] ph_q;

  assign mode_chg = ({lo_sel, cplx_en} != mode_q);
  assign ph_eff   = mode_chg ? '0 : ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ph_q   <= '0;
    end else begin
      mode_q <= {lo_sel, cplx_en};
      ph_q   <= adv ? ph_eff + 1'b1 : ph_eff;
    end
  end
endmodule

// File: rtl/qmix_rotator.sv
`timescale 1ns/1ps
module qmix_rotator
  import qmix_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] x_q,
  input  logic [1:0]    ph,
  input  logic [1:0]    lo_sel,
  input  logic          cplx_en,
  output logic [DW-1:0] y_i,
  output logic [DW-1:0] y_q
);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  function automatic logic [DW-1:0] neg_sat(input logic [DW-1:0] v);
    if (v == SMIN) return SMAX;
    return (~v) + 1'b1;
  endfunction

  always_comb begin
    y_i = x_i;
    y_q = x_q;
    case (lo_e'(lo_sel))
      LO_HALF: begin
        if (ph[0]) begin
          y_i = neg_sat(x_i);
          y_q = neg_sat(x_q);
        end
      end
      LO_QUART: begin
        case (ph)
          2'd1: begin
            y_i = cplx_en ? neg_sat(x_q) : '0;
            y_q = cplx_en ? x_i : '0;
          end
          2'd2: begin
            y_i = neg_sat(x_i);
            y_q = neg_sat(x_q);
          end
          2'd3: begin
            y_i = cplx_en ? x_q : '0;
            y_q = cplx_en ? neg_sat(x_i) : '0;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/quad_mixer.sv
`timescale 1ns/1ps
module quad_mixer
  import qmix_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [1:0]    lo_sel,
  input  logic          cplx_en,
  output logic          out_valid,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q
);
  logic [PH_W-1:0] ph_eff;
  logic            mode_chg;
  logic [DW-1:0]   mix_i, mix_q;

  qmix_phase #(.PW(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .adv(in_valid),
    .lo_sel(lo_sel), .cplx_en(cplx_en),
    .ph_eff(ph_eff), .mode_chg(mode_chg)
  );

  qmix_rotator #(.DW(DW)) u_rot (
    .x_i(in_i), .x_q(in_q), .ph(ph_eff),
    .lo_sel(lo_sel), .cplx_en(cplx_en),
    .y_i(mix_i), .y_q(mix_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= mix_i;
        out_q <= mix_q;
      end
    end
  end
endmodule

// File: rtl/qmix_chk.sv
`timescale 1ns/1ps
module qmix_chk #(
  parameter int unsigned DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_i,
  input logic [DW-1:0] in_q,
  input logic [1:0]    lo_sel,
  input logic          cplx_en,
  input logic          out_valid,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q,
  input logic [1:0]    ph_eff,
  input logic          mode_chg
);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_pass_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (lo_sel == 2'b00 || lo_sel == 2'b11)) |=>
      (out_i == $past(in_i) && out_q == $past(in_q)));
  p_half_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_sel == 2'b01 && ph_eff[0] && in_i == SMIN) |=> out_i == SMAX);
  p_real_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lo_sel == 2'b10 && !cplx_en && ph_eff[0]) |=> (out_i == '0 && out_q == '0));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_chg) |=> (out_i == $past(in_i) && out_q == $past(in_q)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_i) && $stable(out_q)));
endmodule

bind quad_mixer qmix_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .lo_sel(lo_sel), .cplx_en(cplx_en), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .ph_eff(ph_eff), .mode_chg(mode_chg)
);

// File: tb/quad_mixer_test.sv
`timescale 1ns/1ps
module quad_mixer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [11:0] in_i = '0, in_q = '0;
  logic [1:0] lo_sel = '0;
  logic cplx_en = 1'b0;
  logic out_valid;
  logic [11:0] out_i, out_q;

  int checks = 0, failures = 0;
  int m_ph = 0, m_prev = 0, e_i = 0, e_q = 0, e_v = 0;
  bit prev_idle = 1'b0;

  always #2 clk = ~clk;

  quad_mixer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .lo_sel(lo_sel), .cplx_en(cplx_en), .out_valid(out_valid),
    .out_i(out_i), .out_q(out_q)
  );

  function automatic int sat12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input int xi, input int xq, input int lo, input bit cx);
    int c, s, ri, rq;
    bit chg;
    string tag;
    @(negedge clk);
    in_valid = v; in_i = xi[11:0]; in_q = xq[11:0];
    lo_sel = lo[1:0]; cplx_en = cx;
    chg = ((lo * 2 + cx) != m_prev);
    if (chg) m_ph = 0;
    m_prev = lo * 2 + cx;
    tag = "R10";
    if (v) begin
      c = 1; s = 0;
      if (lo == 1) c = (m_ph % 2) ? -1 : 1;
      if (lo == 2) begin
        c = (m_ph == 0) ? 1 : (m_ph == 2) ? -1 : 0;
        s = (m_ph == 1) ? 1 : (m_ph == 3) ? -1 : 0;
      end
      if (lo == 2 && cx) begin
        ri = xi * c - xq * s; rq = xi * s + xq * c;
      end else begin
        ri = xi * c; rq = xq * c;
      end
      e_i = sat12(ri); e_q = sat12(rq);
      if (chg) tag = "R9";
      else if (prev_idle) tag = "R8";
      else if (ri != e_i || rq != e_q) tag = "R7";
      else if (lo == 1) tag = "R4";
      else if (lo == 2 && cx) tag = "R5";
      else if (lo == 2) tag = "R6";
      else tag = "R3";
      m_ph = (m_ph + 1) % 4;
    end
    e_v = v;
    prev_idle = !v;
    @(posedge clk); #1;
    check("R2", int'(out_valid), e_v);
    check(tag, int'($signed(out_i)), e_i);
    check(tag, int'($signed(out_q)), e_q);
  endtask

  initial begin
    #(4 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'($signed(out_i)), 0);
    check("R1", int'($signed(out_q)), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", int'(out_valid), 0);
    check("R1", int'($signed(out_i)), 0);

    for (int lo = 0; lo < 4; lo++) begin
      for (int cx = 0; cx < 2; cx++) begin
        for (int k = 0; k < 40; k++) begin
          int xi, xq;
          xi = ((k * 613 + lo * 97 + cx * 11) % 4096) - 2048;
          xq = ((k * 389 + 5 + lo * 7) % 4096) - 2048;
          if (k % 9 == 4) xi = -2048;
          if (k % 11 == 6) xq = -2048;
          drive((k % 7) != 5, xi, xq, lo, cx[0]);
        end
      end
    end

    // R9 with R7: restart into half rate, then saturating negation at phase 1
    drive(1, 5, -9, 1, 0);
    drive(1, -2048, -2048, 1, 0);
    // R9 on an idle cycle, then the quarter-rate complex sequence from phase 0
    drive(0, 0, 0, 2, 1);
    drive(1, 100, 200, 2, 1);
    drive(1, -2048, -2048, 2, 1);
    drive(1, 300, -400, 2, 1);
    drive(1, -2048, 77, 2, 1);
    // R8: idle gap in the middle of the quarter-rate sequence
    drive(0, 1, 1, 2, 1);
    drive(0, 1, 1, 2, 1);
    drive(1, 11, 22, 2, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule